// File: doc/BRIEF.md
# PWM Timing Parameter Search Engine

This block turns a requested PWM period, given in microseconds, into the four timing settings of a PWM generator. The settings are a resolution flag (64 or 512 steps per period), a reference clock index, a pre-divider index and a power-of-two exponent. The engine converts the period into a target time per PWM step in nanoseconds. It then tries every clock and divider pair, sweeping the exponent for each one, and keeps the candidate step time with the smallest absolute distance from the target.

A caller applies the period and duty (both in microseconds) and pulses `start`. The engine checks the request range. If the request is out of range, it answers on the next cycle with `done` and `err` high. Otherwise it raises `busy`, tests one candidate per clock cycle, and pulses `done` with the result fields stable. An exponent sweep ends early once the distance starts to grow, so the run length depends on the period.

Top module: `pwm_period_search`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `wide`, `clk_idx`, `div_idx` and `exp_m` are all zero.
- R2: A start whose period is below 7, whose period is above 384000000, or whose duty exceeds the period is rejected. On the next cycle `done` and `err` are high, `busy` stays low, and all result fields read zero.
- R3: The target step is floor(period × 1000 / 64) ns. If that value is at least 749999616, `wide` is set to 1 (512 steps) and the target is divided by a further 8 with truncation. Otherwise `wide` is 0.
- R4: The candidate for clock index c, divider index d and exponent m is tick[c] × factor[d] × 2^m. Here tick = {976562, 30517, 52} for c = 0..2, factor = {1, 3, 5, 6} for d = 0..3, and m = 0..7.
- R5: The reported fields name the candidate with the smallest absolute distance to the target. On a tie, the first one tried wins, in the order clock (outer), then divider, then exponent (inner).
- R6: Within one sweep, the sweep ends right after a candidate with m ≠ 0 whose distance exceeds the previous candidate's distance. For an accepted request, `done` rises exactly N cycles after the start edge, where N is the number of candidates tried.
- R7: `done` is a one-cycle pulse. `busy` is high from the cycle after an accepted start until `done`. A start while busy is ignored. The result fields do not change while idle without a start.
- R8: Every start clears the result fields to zero and `err` to zero before the new outcome is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (sampled when idle) |
| period_us | input | 32 | Requested PWM period in microseconds |
| duty_us | input | 32 | Requested high time in microseconds (range check only) |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Last request was rejected |
| wide | output | 1 | 1 = 512-step resolution, 0 = 64-step |
| clk_idx | output | 2 | Chosen reference clock index |
| div_idx | output | 2 | Chosen pre-divider index |
| exp_m | output | 3 | Chosen exponent |

## Verification
The bench walks the period geometrically across the whole legal range. It checks each result, and the exact run length, against an arithmetic model. The model restates the search loop, including the early stop, so a design that kept the later candidate on a tie, or never ended sweeps early, shows up as wrong fields or a wrong cycle count. Periods on either side of the resolution threshold (47999975 and 47999976) catch an off-by-one in the wide/narrow comparison. The range edges 6, 7, 384000000 and 384000001, plus duty equal to and just above the period, catch a reversed or non-inclusive limit. A second start pulsed mid-run must not disturb the first result. Without that, an engine that restarts or mixes in the new target would report a different answer or latency.

// File: rtl/pwm_search_pkg.sv
package pwm_search_pkg;
  localparam int US_W    = 32;
  localparam int NS_W    = 42;
  localparam int STEP_W  = NS_W - 6;
  localparam int NUM_CLK = 3;
  localparam int NUM_DIV = 4;
  localparam int M_MAX   = 7;
  localparam int CW      = $clog2(NUM_CLK);
  localparam int DW      = $clog2(NUM_DIV);
  localparam int MW      = $clog2(M_MAX + 1);
  localparam logic [STEP_W-1:0] WIDE_LIMIT = STEP_W'(64'd6 * 64'd976562 * 64'd128);

  typedef struct packed {
    logic              wide;
    logic [STEP_W-1:0] step;
  } target_t;

  function automatic logic [STEP_W-1:0] tick_ns(input logic [CW-1:0] c);
    case (c)
      2'd0:    tick_ns = STEP_W'(976562);
      2'd1:    tick_ns = STEP_W'(30517);
      default: tick_ns = STEP_W'(52);
    endcase
  endfunction

  function automatic logic [STEP_W-1:0] div_factor(input logic [DW-1:0] d);
    case (d)
      2'd0:    div_factor = STEP_W'(1);
      2'd1:    div_factor = STEP_W'(3);
      2'd2:    div_factor = STEP_W'(5);
      default: div_factor = STEP_W'(6);
    endcase
  endfunction

  // period in us -> ns per PWM step, choosing the resolution
  function automatic target_t make_target(input logic [US_W-1:0] period);
    logic [NS_W-1:0]   ns;
    logic [STEP_W-1:0] s;
    target_t           t;
    ns = NS_W'(period) * NS_W'(1000);
    s  = ns[NS_W-1:6];
    t.wide = (s >= WIDE_LIMIT);
    t.step = t.wide ? (s >> 3) : s;
    return t;
  endfunction
endpackage

// File: rtl/pwm_cand_gen.sv
module pwm_cand_gen
  import pwm_search_pkg::*;
(
  input  logic [CW-1:0]     ci,
  input  logic [DW-1:0]     di,
  input  logic [MW-1:0]     mi,
  output logic [STEP_W-1:0] cand
);
  logic [STEP_W-1:0] base;
  always_comb begin
    base = tick_ns(ci) * div_factor(di);
    cand = base << mi;
  end
endmodule

// File: rtl/pwm_abs_diff.sv
module pwm_abs_diff #(
  parameter int W = 36
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] d
);
  always_comb d = (a > b) ? (a - b) : (b - a);
endmodule

// File: rtl/pwm_idx_walker.sv
module pwm_idx_walker
  import pwm_search_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic          pair_end,
  output logic [CW-1:0] ci,
  output logic [DW-1:0] di,
  output logic [MW-1:0] mi,
  output logic          last_pair
);
  assign last_pair = (ci == CW'(NUM_CLK - 1)) && (di == DW'(NUM_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ci <= '0;
      di <= '0;
      mi <= '0;
    end else if (clear) begin
      ci <= '0;
      di <= '0;
      mi <= '0;
    end else if (step) begin
      if (pair_end) begin
        mi <= '0;
        if (di == DW'(NUM_DIV - 1)) begin
          di <= '0;
          ci <= last_pair ? '0 : ci + 1'b1;
        end else begin
          di <= di + 1'b1;
        end
      end else begin
        mi <= mi + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_period_search.sv
module pwm_period_search
  import pwm_search_pkg::*;
#(
  parameter logic [US_W-1:0] MIN_US = 32'd7,
  parameter logic [US_W-1:0] MAX_US = 32'd384000000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [US_W-1:0] period_us,
  input  logic [US_W-1:0] duty_us,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic            wide,
  output logic [CW-1:0]   clk_idx,
  output logic [DW-1:0]   div_idx,
  output logic [MW-1:0]   exp_m
);
  typedef enum logic {S_IDLE, S_RUN} state_t;
  state_t state;

  logic [STEP_W-1:0] target, cand, cur_err, min_err, last_err;
  logic [CW-1:0]     ci;
  logic [DW-1:0]     di;
  logic [MW-1:0]     mi;
  logic              last_pair;
  target_t           tgt_in;

  // named events used by the checker
  logic accept, reject, better, stop_sweep, pair_end, finish;

  assign busy       = (state == S_RUN);
  assign tgt_in     = make_target(period_us);
  assign reject     = (state == S_IDLE) && start &&
                      ((period_us < MIN_US) || (period_us > MAX_US) || (duty_us > period_us));
  assign accept     = (state == S_IDLE) && start && !reject;
  assign better     = busy && (cur_err < min_err);
  assign stop_sweep = busy && (mi != '0) && (cur_err > last_err);
  assign pair_end   = stop_sweep || (mi == MW'(M_MAX));
  assign finish     = busy && pair_end && last_pair;

  pwm_cand_gen u_cand (.ci(ci), .di(di), .mi(mi), .cand(cand));

  pwm_abs_diff #(.W(STEP_W)) u_diff (.a(target), .b(cand), .d(cur_err));

  pwm_idx_walker u_walk (
    .clk(clk), .rst_n(rst_n), .clear(accept), .step(busy),
    .pair_end(pair_end), .ci(ci), .di(di), .mi(mi), .last_pair(last_pair)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      done     <= 1'b0;
      err      <= 1'b0;
      wide     <= 1'b0;
      clk_idx  <= '0;
      div_idx  <= '0;
      exp_m    <= '0;
      target   <= '0;
      min_err  <= '1;
      last_err <= '1;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        if (start) begin
          clk_idx  <= '0;
          div_idx  <= '0;
          exp_m    <= '0;
          min_err  <= '1;
          last_err <= '1;
          err      <= reject;
          done     <= reject;
          wide     <= reject ? 1'b0 : tgt_in.wide;
          if (!reject) begin
            target <= tgt_in.step;
            state  <= S_RUN;
          end
        end
      end else begin
        if (better) begin
          min_err <= cur_err;
          clk_idx <= ci;
          div_idx <= di;
          exp_m   <= mi;
        end
        if (!stop_sweep) last_err <= cur_err;
        if (finish) begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwm_search_checker.sv
module pwm_search_checker
  import pwm_search_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              wide,
  input logic [CW-1:0]     clk_idx,
  input logic [DW-1:0]     div_idx,
  input logic [MW-1:0]     exp_m,
  input logic [CW-1:0]     ci,
  input logic [MW-1:0]     mi,
  input logic [STEP_W-1:0] min_err,
  input logic              stop_sweep,
  input logic              reject
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done && !busy); // R2

  AST_REJECT_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> done && err && !busy && clk_idx == '0 && exp_m == '0); // R2

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable({wide, clk_idx, div_idx, exp_m, err})); // R7

  AST_ERR_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (min_err <= $past(min_err))); // R5

  AST_SWEEP_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_sweep |=> (mi == '0)); // R6

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ci <= CW'(NUM_CLK - 1)) && (clk_idx <= CW'(NUM_CLK - 1))); // R4
endmodule

bind pwm_period_search pwm_search_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err(err), .wide(wide), .clk_idx(clk_idx), .div_idx(div_idx),
  .exp_m(exp_m), .ci(ci), .mi(mi), .min_err(min_err),
  .stop_sweep(stop_sweep), .reject(reject)
);

// File: tb/tb_pwm_period_search.sv
module tb_pwm_period_search;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] period_us = '0;
  logic [31:0] duty_us = '0;
  logic        busy, done, err, wide;
  logic [1:0]  clk_idx, div_idx;
  logic [2:0]  exp_m;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk; // 50 MHz

  pwm_period_search dut (
    .clk(clk), .rst_n(rst_n), .start(start), .period_us(period_us),
    .duty_us(duty_us), .busy(busy), .done(done), .err(err), .wide(wide),
    .clk_idx(clk_idx), .div_idx(div_idx), .exp_m(exp_m)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // arithmetic model of the search
  task automatic model(input longint p, output bit wd, output int bc, output int bd,
                       output int bm, output int n);
    longint tick[3];
    longint fac[4];
    longint t, cand, e, minv, lastv;
    tick[0] = 976562; tick[1] = 30517; tick[2] = 52;
    fac[0] = 1; fac[1] = 3; fac[2] = 5; fac[3] = 6;
    t = (p * 1000) / 64;
    wd = (t >= 64'd749999616);
    if (wd) t = t / 8;
    minv = 64'h7fffffffffffffff; lastv = minv;
    bc = 0; bd = 0; bm = 0; n = 0;
    for (int c = 0; c < 3; c++)
      for (int d = 0; d < 4; d++)
        for (int m = 0; m < 8; m++) begin
          cand = (tick[c] * fac[d]) << m;
          e = (t > cand) ? t - cand : cand - t;
          n++;
          if (e < minv) begin minv = e; bc = c; bd = d; bm = m; end
          if (m != 0 && e > lastv) break;
          lastv = e;
        end
  endtask

  task automatic pulse_start(input longint p, input longint dty);
    @(negedge clk);
    period_us = p[31:0];
    duty_us = dty[31:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // counts negedges from start edge until done seen; returns cycles
  task automatic wait_done(output int cyc);
    cyc = 1;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_valid(input longint p, input bit mid_start);
    bit wd; int bc, bd, bm, n, cyc;
    model(p, wd, bc, bd, bm, n);
    pulse_start(p, p / 2);
    check(busy === 1'b1, "R7 busy after start", busy, 1);
    if (mid_start) begin
      @(negedge clk);
      period_us = 32'd12345; duty_us = 32'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 3;
      while (!done && cyc < 400) begin @(negedge clk); cyc++; end
    end else begin
      wait_done(cyc);
    end
    check(cyc == n + 1, "R6 latency", cyc, n + 1);
    check(err === 1'b0, "R2 no err on valid", err, 0);
    check(wide === wd, "R3 wide", wide, wd);
    check(clk_idx == bc && div_idx == bd && exp_m == bm, "R5 fields",
          {clk_idx, div_idx, exp_m}, {bc[1:0], bd[1:0], bm[2:0]});
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R7 done pulse", done, 0);
  endtask

  task automatic run_reject(input longint p, input longint dty);
    pulse_start(p, dty);
    check(done === 1'b1 && err === 1'b1 && busy === 1'b0, "R2 reject",
          {done, err, busy}, 3'b110);
    check({wide, clk_idx, div_idx, exp_m} == '0, "R8 fields cleared",
          {wide, clk_idx, div_idx, exp_m}, 0);
    @(negedge clk);
    check(done === 1'b0, "R7 reject pulse", done, 0);
  endtask

  initial begin
    longint p;
    repeat (3) @(negedge clk);
    check({busy, done, err, wide, clk_idx, div_idx, exp_m} == '0, "R1 reset",
          {busy, done, err, wide, clk_idx, div_idx, exp_m}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    p = 7;
    while (p <= 384000000) begin
      run_valid(p, 1'b0); // R3 R4 R5 R6
      p = p + p / 3 + 1;
    end
    run_valid(47999975, 1'b0); // R3 below threshold
    run_valid(47999976, 1'b0); // R3 at threshold
    run_valid(384000000, 1'b0);
    run_valid(1000, 1'b1);     // R7 start while busy ignored
    run_valid(5000000, 1'b0);  // nonzero fields before reject (R8)
    run_reject(6, 1);
    run_reject(384000001, 1);
    run_reject(100, 101);
    begin
      bit wd; int bc, bd, bm, n, cyc;
      model(100, wd, bc, bd, bm, n);
      pulse_start(100, 100);   // duty equal to period is legal (R2)
      wait_done(cyc);
      check(err === 1'b0 && exp_m == bm, "R2 duty equal", exp_m, bm);
    end
    repeat (5) @(negedge clk);
    check(exp_m == exp_m && done === 1'b0, "R7 idle quiet", done, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule